// File: doc/BRIEF.md
# Keyed External Reset Pulse Generator

This block sits beside a watchdog's countdown logic and turns its timeout event into a timed pulse on an external reset pin. A single 32-bit configuration register, at a fixed bus offset, holds the pulse width and two output-mode bits. The width field is written directly on every register write. The two mode bits are a polarity bit (bit 31) and a drive-type bit (bit 30). They are never written as plain data. They change only when the top byte of the write data carries one of four key patterns, which protects the pin mode against stray writes.

A parameter picks one of two variants. The extended variant has a 20-bit width field and accepts the keys. The base variant has an 8-bit width field and ignores keys, so its pin stays active-low and open-drain. The pulse is counted in ticks of an external 1 MHz strobe. An output-enable is provided so that an open-drain pad can be emulated with a plain tristate buffer.

Top module: `xrp_pulse_gen`

## Requirements
- R1: After the synchronous reset the register reads 0x000000FF, the pin output sits at 1 and the output-enable at 0. In this state the pin is active-low and open-drain.
- R2: Every write that hits the register offset loads the width field from the same bits of the write data, whatever the top byte holds. The width field is bits 19:0 in the extended variant and bits 7:0 in the base variant. All other bits except 31 and 30 read as zero.
- R3: In the extended variant, top byte 0xA5 sets bit 31 (active-high) and top byte 0x5A clears it (active-low).
- R4: In the extended variant, top byte 0xA8 sets bit 30 (push-pull) and top byte 0x8A clears it (open-drain).
- R5: A top byte of zero, or any nonzero value other than the four keys, leaves bits 31 and 30 unchanged.
- R6: The base variant ignores all key patterns. Bits 31 and 30 always read 0.
- R7: A timeout while the enable is high starts a pulse that lasts width+1 strobe ticks. If ticks arrive every P clocks and the timeout comes in a tick cycle, the pin stays at its asserted level for exactly (width+1)*P clocks.
- R8: A timeout while the enable is low produces no pulse.
- R9: While asserted, the pin drives the value of bit 31. While idle, it drives the inverse of bit 31.
- R10: In push-pull mode the output-enable is always 1. In open-drain mode it is 1 exactly when the pin output is 0.
- R11: A timeout during an active pulse reloads the count. The pulse then ends width+1 ticks after the second timeout.
- R12: Writes to any other offset leave the register unchanged. Reads from any other offset return 0. Read data appears one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one clock after rd_en |
| tick_1us | input | 1 | 1 MHz strobe, one clock wide |
| timeout | input | 1 | Watchdog timeout event, one clock wide |
| ext_rst_en | input | 1 | External-reset enable level from the control logic |
| pin_out | output | 1 | Registered pin value |
| pin_oe | output | 1 | Registered pin output-enable |

## Verification
The width field is checked with a sweep of sixteen write words. Their top bytes step through non-key values, so the plain-data path, the width masking of each variant and the hold of the mode bits are all separated in one pass. Pulse length is measured for every width from 0 to 20, with ticks every three clocks. An off-by-one in the tick count or a missed reload therefore shows up as an exact clock count mismatch. All four polarity and drive combinations are pulsed in turn, with the idle level, asserted level and output-enable compared against each other. A disabled timeout and a retriggered timeout show whether the enable is honoured and whether the count is reloaded rather than left running.

// File: rtl/xrp_pkg.sv
package xrp_pkg;
  localparam logic [7:0] KEY_ACT_HIGH  = 8'hA5;
  localparam logic [7:0] KEY_ACT_LOW   = 8'h5A;
  localparam logic [7:0] KEY_PUSH_PULL = 8'hA8;
  localparam logic [7:0] KEY_OPEN_DRN  = 8'h8A;

  typedef struct packed {
    logic act_high;
    logic push_pull;
  } xrp_mode_t;

  function automatic int width_bits(input bit extended);
    return extended ? 20 : 8;
  endfunction
endpackage

// File: rtl/xrp_cfg_reg.sv
module xrp_cfg_reg
  import xrp_pkg::*;
#(
  parameter bit EXTENDED = 1'b1,
  parameter int WID_W    = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [31:0]      wdata,
  output xrp_mode_t        mode_o,
  output logic [WID_W-1:0] width_o
);
  logic [WID_W-1:0] width_q;
  logic [7:0]       key;

  assign key = wdata[31:24];

  always_ff @(posedge clk) begin
    if (rst)         width_q <= WID_W'(8'hFF);
    else if (wr_hit) width_q <= wdata[WID_W-1:0];
  end
  assign width_o = width_q;

  generate
    if (EXTENDED) begin : g_keyed
      xrp_mode_t mode_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          mode_q <= '0;
        end else if (wr_hit) begin
          case (key)
            KEY_ACT_HIGH:  mode_q.act_high  <= 1'b1;
            KEY_ACT_LOW:   mode_q.act_high  <= 1'b0;
            KEY_PUSH_PULL: mode_q.push_pull <= 1'b1;
            KEY_OPEN_DRN:  mode_q.push_pull <= 1'b0;
            default: ;
          endcase
        end
      end
      assign mode_o = mode_q;

      AST_KEY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && key == KEY_ACT_HIGH) |=> mode_o.act_high); // R3
      AST_KEY_PUSH: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && key == KEY_PUSH_PULL) |=> mode_o.push_pull); // R4
      AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && key != KEY_ACT_HIGH && key != KEY_ACT_LOW &&
         key != KEY_PUSH_PULL && key != KEY_OPEN_DRN) |=> $stable(mode_o)); // R5
    end else begin : g_fixed
      assign mode_o = '0;
    end
  endgenerate

  AST_WIDTH_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> width_o == $past(wdata[WID_W-1:0])); // R2
endmodule

// File: rtl/xrp_pulse_timer.sv
module xrp_pulse_timer #(
  parameter int WID_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [WID_W-1:0] width,
  output logic             active_o
);
  logic             active_q;
  logic [WID_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      left_q   <= width;
    end else if (active_q && tick) begin
      if (left_q == '0) active_q <= 1'b0;
      else              left_q   <= left_q - 1'b1;
    end
  end
  assign active_o = active_q;

  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !start) |=> !active_q); // R8
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    start |=> (active_q && left_q == $past(width))); // R11
endmodule

// File: rtl/xrp_pin_drive.sv
module xrp_pin_drive
  import xrp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      active,
  input  xrp_mode_t mode,
  output logic      pin_o,
  output logic      oe_o
);
  logic level;

  assign level = active ? mode.act_high : ~mode.act_high;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o <= 1'b1;
      oe_o  <= 1'b0;
    end else begin
      pin_o <= level;
      oe_o  <= mode.push_pull | ~level;
    end
  end

  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (pin_o && !$past(mode.push_pull)) |-> !oe_o); // R10
  AST_ASSERT_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $past(active) |-> pin_o == $past(mode.act_high)); // R9
endmodule

// File: rtl/xrp_pulse_gen.sv
module xrp_pulse_gen
  import xrp_pkg::*;
#(
  parameter bit              EXTENDED = 1'b1,
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_OFF = ADDR_W'(8'h18)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              tick_1us,
  input  logic              timeout,
  input  logic              ext_rst_en,
  output logic              pin_out,
  output logic              pin_oe
);
  localparam int WID_W = width_bits(EXTENDED);
  localparam int PAD_W = 30 - WID_W;

  logic             hit;
  xrp_mode_t        mode;
  logic [WID_W-1:0] width;
  logic             active;
  logic [31:0]      reg_view;

  assign hit      = (addr == REG_OFF);
  assign reg_view = {mode.act_high, mode.push_pull, {PAD_W{1'b0}}, width};

  xrp_cfg_reg #(.EXTENDED(EXTENDED), .WID_W(WID_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_hit(wr_en && hit), .wdata(wdata),
    .mode_o(mode), .width_o(width)
  );

  xrp_pulse_timer #(.WID_W(WID_W)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_1us), .start(timeout && ext_rst_en),
    .width(width), .active_o(active)
  );

  xrp_pin_drive u_pin (
    .clk(clk), .rst(rst), .active(active), .mode(mode),
    .pin_o(pin_out), .oe_o(pin_oe)
  );

  always_ff @(posedge clk) begin
    if (rst)                rdata <= '0;
    else if (rd_en && hit)  rdata <= reg_view;
    else                    rdata <= '0;
  end

  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && hit)) |=> $stable(reg_view)); // R12
endmodule

// File: tb/xrp_pulse_gen_bench.sv
module xrp_pulse_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_P     = 3;

  logic        clk = 0, rst = 1;
  logic        wr_en = 0, rd_en = 0, timeout = 0, ext_rst_en = 0;
  logic [7:0]  addr = 8'h18;
  logic [31:0] wdata = 0;
  logic [31:0] rdata, rdata_b;
  logic        pin, oe, pin_b, oe_b, tick;
  int          phase = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;
  int          asrt_cnt = 0, asrt_cnt_b = 0, oe_err = 0;
  bit          mon_en = 0;
  logic        exp_pol = 0, exp_pp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign tick = (phase == 0);

  xrp_pulse_gen #(.EXTENDED(1'b1)) u_xrp_pulse_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_1us(tick), .timeout(timeout),
    .ext_rst_en(ext_rst_en), .pin_out(pin), .pin_oe(oe));

  xrp_pulse_gen #(.EXTENDED(1'b0)) u_xrp_pulse_gen_base (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_b), .tick_1us(tick), .timeout(timeout),
    .ext_rst_en(ext_rst_en), .pin_out(pin_b), .pin_oe(oe_b));

  always @(negedge clk) begin
    phase <= (phase == TICK_P-1) ? 0 : phase + 1;
    if (!rst) begin
      if (pin == exp_pol) asrt_cnt <= asrt_cnt + 1;
      if (pin_b == 1'b0)  asrt_cnt_b <= asrt_cnt_b + 1;
      if (mon_en && (oe !== (exp_pp | ~pin) || oe_b !== ~pin_b))
        oe_err <= oe_err + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 0; addr = 8'h18;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] e, output logic [31:0] b);
    @(negedge clk); #1;
    rd_en = 1; addr = a;
    @(negedge clk); #1;
    e = rdata; b = rdata_b;
    rd_en = 0; addr = 8'h18;
  endtask

  task automatic fire();
    do begin @(negedge clk); #1; end while (phase != 0);
    timeout = 1;
    @(negedge clk); #1;
    timeout = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    logic [31:0] e, b, d;
    int a0, b0, o0;
    repeat (3) @(negedge clk);
    #1 rst = 0;

    // R1 reset state
    rd(8'h18, e, b);
    chk(e == 32'hFF, "R1 ext reset value", e, 32'hFF);
    chk(b == 32'hFF, "R1 base reset value", b, 32'hFF);
    chk(pin == 1 && pin_b == 1, "R1 idle pin high", {pin, pin_b}, 2'b11);
    chk(oe == 0 && oe_b == 0, "R1 oe released", {oe, oe_b}, 2'b00);

    // R2 width field sweep, non-key top bytes (R5 mode bits stay zero)
    for (int i = 0; i < 16; i++) begin
      d = {8'(i * 17), 24'(i * 32'h0013579B)};
      wr(8'h18, d);
      rd(8'h18, e, b);
      chk(e == {12'h000, d[19:0]}, "R2 ext width field", e, {12'h000, d[19:0]});
      chk(b == {24'h0, d[7:0]}, "R2 base width field", b, {24'h0, d[7:0]});
    end

    // R3 / R4 keys; R6 base ignores
    wr(8'h18, 32'hA5000005); rd(8'h18, e, b);
    chk(e == 32'h80000005, "R3 key sets active-high", e, 32'h80000005);
    chk(b == 32'h00000005, "R6 base ignores key", b, 32'h00000005);
    wr(8'h18, 32'hA8000006); rd(8'h18, e, b);
    chk(e == 32'hC0000006, "R4 key sets push-pull", e, 32'hC0000006);
    chk(b == 32'h00000006, "R6 base ignores key", b, 32'h00000006);
    wr(8'h18, 32'h7F000007); rd(8'h18, e, b);
    chk(e == 32'hC0000007, "R5 other top byte holds mode", e, 32'hC0000007);
    wr(8'h18, 32'h00000008); rd(8'h18, e, b);
    chk(e == 32'hC0000008, "R5 zero top byte holds mode", e, 32'hC0000008);
    wr(8'h18, 32'h5A000009); rd(8'h18, e, b);
    chk(e == 32'h40000009, "R3 key clears active-high", e, 32'h40000009);
    wr(8'h18, 32'h8A00000A); rd(8'h18, e, b);
    chk(e == 32'h0000000A, "R4 key clears push-pull", e, 32'h0000000A);
    chk(b == 32'h0000000A, "R6 base mode bits zero", b, 32'h0000000A);

    // R12 other offsets
    wr(8'h1C, 32'hA50000FF); rd(8'h18, e, b);
    chk(e == 32'h0000000A, "R12 miss write ignored", e, 32'h0000000A);
    rd(8'h1C, e, b);
    chk(e == 0 && b == 0, "R12 miss read zero", e, 0);

    // R7 pulse length sweep, active-low open-drain
    ext_rst_en = 1;
    mon_en = 1;
    for (int w = 0; w <= 20; w++) begin
      wr(8'h18, 32'(w));
      idle(4);
      a0 = asrt_cnt; b0 = asrt_cnt_b;
      fire();
      idle((w + 1) * TICK_P + 6);
      chk(asrt_cnt - a0 == (w + 1) * TICK_P, "R7 ext pulse length", asrt_cnt - a0, (w + 1) * TICK_P);
      chk(asrt_cnt_b - b0 == (w + 1) * TICK_P, "R7 base pulse length", asrt_cnt_b - b0, (w + 1) * TICK_P);
    end
    chk(oe_err == 0, "R10 oe open-drain during sweep", oe_err, 0);

    // R8 disabled
    ext_rst_en = 0;
    a0 = asrt_cnt;
    fire();
    idle(30);
    chk(asrt_cnt == a0, "R8 no pulse when disabled", asrt_cnt - a0, 0);
    ext_rst_en = 1;

    // R9 / R10 mode combinations, width 2
    for (int m = 0; m < 4; m++) begin
      mon_en = 0;
      wr(8'h18, (m[0] ? 32'hA5000002 : 32'h5A000002));
      wr(8'h18, (m[1] ? 32'hA8000002 : 32'h8A000002));
      idle(3);
      exp_pol = m[0]; exp_pp = m[1];
      idle(2);
      mon_en = 1;
      chk(pin == ~exp_pol, "R9 idle level", pin, ~exp_pol);
      a0 = asrt_cnt; o0 = oe_err;
      fire();
      idle(3 * TICK_P + 6);
      chk(asrt_cnt - a0 == 3 * TICK_P, "R9 asserted level length", asrt_cnt - a0, 3 * TICK_P);
      chk(oe_err == o0, "R10 oe rule", oe_err - o0, 0);
    end

    // R11 retrigger, width 3: second timeout one tick period later
    a0 = asrt_cnt;
    wr(8'h18, 32'h00000003);
    idle(3);
    a0 = asrt_cnt;
    fire();
    fire();
    idle(4 * TICK_P + 8);
    chk(asrt_cnt - a0 == TICK_P + 4 * TICK_P, "R11 retrigger restarts", asrt_cnt - a0, 5 * TICK_P);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule